// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block performs integer division for a processor execute stage. A single start strobe launches an operation on a dividend and a divisor. Three control bits choose the variant. The first selects a two's-complement or unsigned view of the operands. The second selects the quotient or the remainder as the answer. The third selects the full register width or a narrow word mode. Word mode reads only the low word of each operand and sign-extends the word-sized answer to the full width. This sign-extension applies to the unsigned variants as well.

The datapath is a radix-2 restoring divider that works on operand magnitudes and produces one quotient bit per clock. Signs are stripped before the loop and restored afterwards. A zero divisor and the one signed overflow case (most negative value divided by minus one) are detected when the operation is accepted. They finish after a single clock with fixed values and never trap. The caller holds the operation until the unit reports done. The result stays on the output until the next operation is accepted.

Top module: `divu_top`

## Requirements
- R1: With signed set, both operands are two's-complement and the quotient is truncated toward zero (for example -7 / 2 = -3).
- R2: With signed clear, both operands are unsigned and the quotient is the unsigned floor of dividend / divisor.
- R3: With the remainder select set, the answer is dividend - quotient*divisor of the same division. A nonzero signed remainder has the sign of the dividend, and an unsigned remainder is always smaller than the divisor.
- R4: In word mode only the low WORD_W bits of each operand are used, and the upper operand bits have no effect on the result. The WORD_W-bit answer is sign-extended from bit WORD_W-1 to XLEN bits in the signed and unsigned variants alike.
- R5: When the divisor is zero at the operating width, the quotient is all ones and the remainder equals the dividend. In word mode both values are taken at WORD_W bits and then sign-extended.
- R6: When signed is set and the operating-width dividend is the most negative value while the divisor is all ones, the quotient equals the dividend and the remainder is zero. In word mode both values are taken at WORD_W bits and then sign-extended.
- R7: The accepting clock edge counts as edge 1. A zero-divisor or overflow operation raises done_o after edge 1. Any other operation raises done_o after edge N+1, where N is XLEN in full mode and WORD_W in word mode.
- R8: done_o is high for exactly one cycle, and result_o keeps its value until the next operation is accepted. After reset, done_o and busy_o are low.
- R9: busy_o is high while a division is iterating. A start_i pulse seen while busy_o is high is ignored and does not change that operation's result or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Accept an operation when not busy |
| dividend_i | input | XLEN | Dividend operand |
| divisor_i | input | XLEN | Divisor operand |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| rem_i | input | 1 | 1: return remainder, 0: return quotient |
| word_i | input | 1 | 1: low WORD_W bits with sign-extended result |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle pulse, result_o valid |
| result_o | output | XLEN | Quotient or remainder, held until next accept |

## Verification
The bench uses an 8-bit configuration with a 4-bit word. It sweeps every third dividend, plus the most negative values, against divisors that include zero, one, all ones, the most negative value and several odd and even magnitudes, in all eight control combinations. Sign mismatches between the operands separate truncation toward zero from floor division. Divisors that are all ones only in the low nibble separate the word and full overflow checks. Word-mode dividends with set upper bits show whether upper operand bits leak into the result. A start pulse in the middle of a run and a check one cycle after every done show whether an operation can be disturbed while busy and whether the result is held.

// File: rtl/divu_pkg.sv
package divu_pkg;

    // Per-operation control carried from acceptance to the result stage.
    typedef struct packed {
        logic neg_quo;   // quotient must be negated
        logic neg_rem;   // remainder must be negated
        logic want_rem;  // answer is the remainder
        logic word;      // narrow word mode
    } divu_ctl_t;

    function automatic divu_ctl_t divu_ctl_clear();
        divu_ctl_t c;
        c.neg_quo  = 1'b0;
        c.neg_rem  = 1'b0;
        c.want_rem = 1'b0;
        c.word     = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/divu_prep.sv
module divu_prep
    import divu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    input  logic            sgn,
    input  logic            want_rem,
    input  logic            word,
    output logic [XLEN-1:0] num_mag,
    output logic [XLEN-1:0] den_mag,
    output divu_ctl_t       ctl,
    output logic            special,
    output logic [XLEN-1:0] special_val
);
    localparam int HI = XLEN - WORD_W;

    logic [XLEN-1:0] a_src, b_src, min_neg, spec_raw;
    logic            a_neg, b_neg, by_zero, ovf;

    always_comb begin
        // Bring both operands to XLEN bits at the chosen width.
        a_src = word ? {{HI{sgn & dividend[WORD_W-1]}}, dividend[WORD_W-1:0]} : dividend;
        b_src = word ? {{HI{sgn & divisor[WORD_W-1]}},  divisor[WORD_W-1:0]}  : divisor;
        a_neg = sgn & a_src[XLEN-1];
        b_neg = sgn & b_src[XLEN-1];
        num_mag = a_neg ? ('0 - a_src) : a_src;
        den_mag = b_neg ? ('0 - b_src) : b_src;

        min_neg = word ? {{(HI+1){1'b1}}, {(WORD_W-1){1'b0}}}
                       : {1'b1, {(XLEN-1){1'b0}}};
        by_zero = (b_src == '0);
        ovf     = sgn & ~by_zero & (a_src == min_neg) & (b_src == '1);
        special = by_zero | ovf;

        if (by_zero) spec_raw = want_rem ? dividend : '1;
        else         spec_raw = want_rem ? '0 : dividend;
        special_val = word ? {{HI{spec_raw[WORD_W-1]}}, spec_raw[WORD_W-1:0]} : spec_raw;

        ctl          = divu_ctl_clear();
        ctl.neg_quo  = a_neg ^ b_neg;
        ctl.neg_rem  = a_neg;
        ctl.want_rem = want_rem;
        ctl.word     = word;
    end
endmodule

// File: rtl/divu_core.sv
module divu_core #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            word,
    input  logic [XLEN-1:0] num_mag,
    input  logic [XLEN-1:0] den_mag,
    output logic            running,
    output logic            finish,
    output logic [XLEN-1:0] quo_mag,
    output logic [XLEN-1:0] rem_mag
);
    localparam int CNT_W = $clog2(XLEN + 1);
    localparam int SHIFT = XLEN - WORD_W;

    logic [XLEN:0]    part_q;
    logic [XLEN-1:0]  quo_q, den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [XLEN:0]    shifted, trial;
    logic             fits;

    always_comb begin
        shifted = {part_q[XLEN-1:0], quo_q[XLEN-1]};
        trial   = shifted - {1'b0, den_q};
        fits    = ~trial[XLEN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q  <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            cnt_q   <= '0;
            running <= 1'b0;
            finish  <= 1'b0;
        end else begin
            finish <= 1'b0;
            if (load) begin
                part_q  <= '0;
                quo_q   <= word ? (num_mag << SHIFT) : num_mag;
                den_q   <= den_mag;
                cnt_q   <= word ? CNT_W'(WORD_W) : CNT_W'(XLEN);
                running <= 1'b1;
            end else if (running) begin
                part_q <= fits ? trial : shifted;
                quo_q  <= {quo_q[XLEN-2:0], fits};
                cnt_q  <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    running <= 1'b0;
                    finish  <= 1'b1;
                end
            end
        end
    end

    assign quo_mag = quo_q;
    assign rem_mag = part_q[XLEN-1:0];

    // R7: one quotient bit per cycle, counter steps down by one
    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        (running && !load && cnt_q > CNT_W'(1)) |=> (running && cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R3: partial remainder ends below the divisor
    assert_rem_below_R3: assert property (@(posedge clk) disable iff (rst)
        (running && !load && cnt_q == CNT_W'(1)) |=> (finish && rem_mag < den_q));
endmodule

// File: rtl/divu_fix.sv
module divu_fix
    import divu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic [XLEN-1:0] quo_mag,
    input  logic [XLEN-1:0] rem_mag,
    input  divu_ctl_t       ctl,
    output logic [XLEN-1:0] result
);
    localparam int HI = XLEN - WORD_W;

    logic [XLEN-1:0] q_s, r_s, pick;

    always_comb begin
        q_s  = ctl.neg_quo ? ('0 - quo_mag) : quo_mag;
        r_s  = ctl.neg_rem ? ('0 - rem_mag) : rem_mag;
        pick = ctl.want_rem ? r_s : q_s;
        result = ctl.word ? {{HI{pick[WORD_W-1]}}, pick[WORD_W-1:0]} : pick;
    end
endmodule

// File: rtl/divu_top.sv
module divu_top
    import divu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0] divisor_i,
    input  logic            signed_i,
    input  logic            rem_i,
    input  logic            word_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);
    logic [XLEN-1:0] num_mag, den_mag, spec_val, quo_mag, rem_mag, fixed;
    divu_ctl_t       ctl_new, ctl_q;
    logic            special, accept, running, finish;
    logic            spec_sel_q, spec_done_q;
    logic [XLEN-1:0] spec_val_q;

    divu_prep #(.XLEN(XLEN), .WORD_W(WORD_W)) u_prep (
        .dividend(dividend_i), .divisor(divisor_i), .sgn(signed_i),
        .want_rem(rem_i), .word(word_i), .num_mag(num_mag), .den_mag(den_mag),
        .ctl(ctl_new), .special(special), .special_val(spec_val)
    );

    assign accept = start_i & ~running;

    divu_core #(.XLEN(XLEN), .WORD_W(WORD_W)) u_core (
        .clk(clk), .rst(rst), .load(accept & ~special), .word(word_i),
        .num_mag(num_mag), .den_mag(den_mag), .running(running),
        .finish(finish), .quo_mag(quo_mag), .rem_mag(rem_mag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= divu_ctl_clear();
            spec_sel_q  <= 1'b0;
            spec_done_q <= 1'b0;
            spec_val_q  <= '0;
        end else begin
            spec_done_q <= accept & special;
            if (accept) begin
                ctl_q      <= ctl_new;
                spec_sel_q <= special;
                spec_val_q <= spec_val;
            end
        end
    end

    divu_fix #(.XLEN(XLEN), .WORD_W(WORD_W)) u_fix (
        .quo_mag(quo_mag), .rem_mag(rem_mag), .ctl(ctl_q), .result(fixed)
    );

    assign result_o = spec_sel_q ? spec_val_q : fixed;
    assign busy_o   = running;
    assign done_o   = finish | spec_done_q;

    // R8: done lasts one cycle unless a new corner case is accepted
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> !done_o);

    // R8: result held after done until a new acceptance
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> $stable(result_o));

    // R5 / R6: corner cases complete one edge after acceptance
    assert_corner_fast_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && special) |=> (done_o && !busy_o));

    // R9: not busy while reporting done
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R4: word results are sign-extended
    assert_word_sext_R4: assert property (@(posedge clk) disable iff (rst)
        (done_o && ctl_q.word) |->
        ((result_o[XLEN-1:WORD_W-1] == '0) || (result_o[XLEN-1:WORD_W-1] == '1)));
endmodule

// File: tb/test_divu_top.sv
module test_divu_top;
    localparam int XL = 8;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [XL-1:0] dividend_i = '0;
    logic [XL-1:0] divisor_i = '0;
    logic          signed_i = 1'b0;
    logic          rem_i = 1'b0;
    logic          word_i = 1'b0;
    logic          busy_o, done_o;
    logic [XL-1:0] result_o;

    int n_checks = 0;
    int n_fails  = 0;

    divu_top #(.XLEN(XL), .WORD_W(WW)) i_divu_top (
        .clk(clk), .rst(rst), .start_i(start_i), .dividend_i(dividend_i),
        .divisor_i(divisor_i), .signed_i(signed_i), .rem_i(rem_i), .word_i(word_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // Arithmetic reference. Returns result and whether it is a corner case.
    function automatic logic [XL-1:0] ref_div(input logic [XL-1:0] a, input logic [XL-1:0] b,
                                              input bit sg, input bit rm, input bit wd,
                                              output bit corner);
        int w = wd ? WW : XL;
        int mask = (1 << w) - 1;
        int ua = int'(a) & mask;
        int ub = int'(b) & mask;
        int sa = ua;
        int sb = ub;
        int q, r, v;
        if (sg) begin
            if (ua >= (1 << (w-1))) sa = ua - (1 << w);
            if (ub >= (1 << (w-1))) sb = ub - (1 << w);
        end
        corner = 1'b1;
        if (ub == 0) begin q = mask; r = ua; end
        else if (sg && sa == -(1 << (w-1)) && sb == -1) begin q = ua; r = 0; end
        else begin
            corner = 1'b0;
            if (sg) begin q = sa / sb; r = sa % sb; end
            else    begin q = ua / ub; r = ua % ub; end
        end
        v = (rm ? r : q) & mask;
        if (v >= (1 << (w-1))) v -= (1 << w);
        return XL'(v);
    endfunction

    function automatic string tag_of(input logic [XL-1:0] b, input bit sg, input bit rm,
                                     input bit wd, input bit corner);
        int w = wd ? WW : XL;
        if ((int'(b) & ((1 << w) - 1)) == 0) return "R5";
        if (corner) return "R6";
        if (wd) return "R4";
        if (rm) return "R3";
        return sg ? "R1" : "R2";
    endfunction

    // Launch one operation; returns result and number of edges to done.
    task automatic run_op(input logic [XL-1:0] a, input logic [XL-1:0] b,
                          input bit sg, input bit rm, input bit wd,
                          output logic [XL-1:0] res, output int lat);
        @(negedge clk);
        dividend_i = a; divisor_i = b; signed_i = sg; rem_i = rm; word_i = wd;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            @(posedge clk); #1;
            lat++;
        end
        res = result_o;
    endtask

    task automatic full_check(input logic [XL-1:0] a, input logic [XL-1:0] b,
                              input bit sg, input bit rm, input bit wd);
        logic [XL-1:0] res, exp;
        int lat;
        bit corner;
        exp = ref_div(a, b, sg, rm, wd, corner);
        run_op(a, b, sg, rm, wd, res, lat);
        check(tag_of(b, sg, rm, wd, corner), int'(res), int'(exp));
        check("R7 latency", lat, corner ? 1 : ((wd ? WW : XL) + 1));
        @(posedge clk); #1;
        check("R8 done pulse", int'(done_o), 0);
        check("R8 result hold", int'(result_o), int'(exp));
    endtask

    localparam logic [XL-1:0] DVS [13] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h08, 8'h7f,
                                           8'h80, 8'hff, 8'hf9, 8'h0f, 8'h05, 8'hfe};

    initial begin
        int wd_cnt = 0;
        while (wd_cnt < 240000) begin
            @(posedge clk);
            wd_cnt++;
        end
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [XL-1:0] res;
        int lat;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R8 / R9: reset state
        check("R8 reset done", int'(done_o), 0);
        check("R9 reset busy", int'(busy_o), 0);

        // Directed cases
        full_check(8'hf9, 8'h02, 1, 0, 0);  // R1: -7/2 = -3
        full_check(8'hf9, 8'h02, 1, 1, 0);  // R3: -7%2 = -1
        full_check(8'h07, 8'hfe, 1, 1, 0);  // R3: 7%-2 = 1
        full_check(8'hc7, 8'h02, 0, 0, 1);  // R4: upper bits ignored, 7/2=3
        full_check(8'h0e, 8'h01, 0, 0, 1);  // R4: unsigned word result sign-extended
        full_check(8'h80, 8'hff, 1, 0, 0);  // R6
        full_check(8'h38, 8'h0f, 1, 1, 1);  // R6 word
        full_check(8'h35, 8'h00, 0, 1, 1);  // R5 word remainder

        // R9: start during a run is ignored
        @(negedge clk);
        dividend_i = 8'd100; divisor_i = 8'd7; signed_i = 0; rem_i = 0; word_i = 0;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        check("R9 busy", int'(busy_o), 1);
        @(posedge clk); #1;
        @(negedge clk);
        dividend_i = 8'd5; divisor_i = 8'd0; rem_i = 1; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        lat = 3;
        while (!done_o && lat < 100) begin
            @(posedge clk); #1;
            lat++;
        end
        check("R9 ignored start result", int'(result_o), 14);
        check("R9 ignored start latency", lat, XL + 1);

        // Sweep
        for (int a = 0; a < 256; a += 3) begin
            for (int k = 0; k < 13; k++) begin
                for (int m = 0; m < 8; m++) begin
                    full_check(XL'(a), DVS[k], m[0], m[1], m[2]);
                end
            end
        end
        for (int k = 0; k < 13; k++) begin
            for (int m = 0; m < 8; m++) begin
                full_check(8'h80, DVS[k], m[0], m[1], m[2]);
                full_check(8'hf8, DVS[k], m[0], m[1], m[2]);
                full_check(8'h08, DVS[k], m[0], m[1], m[2]);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule